// File: doc/BRIEF.md
# Real-Time Clock Register Port and Interrupt Sequencer

This block is the host-facing side of a real-time clock. A host reaches it through two addresses. A write to the even address loads a pointer. Reads and writes at the odd address then reach one byte of a 128-entry array. That array holds the time bytes, the three alarm bytes, four control and status registers and general scratch storage.

The block also runs the once-per-second update. A one-second strobe comes from the oscillator divider. When the divider field allows it, the block asks an external calendar to advance by one second. It then holds an update-in-progress flag for a fixed window. At the end of the window it copies the calendar's time bytes into the array, evaluates the alarm, and raises the update-ended interrupt when that interrupt is enabled.

A host-controlled freeze mode stops the refresh so that software can write a new time. Leaving freeze mode hands the written time to the calendar as a load. The calendar arithmetic itself sits outside this block.

Top module: `rtc_regport`

## Requirements
- R1: A write with `bus_addr`=0 stores `bus_wdata[6:0]` as the pointer. A write or read with `bus_addr`=1 reaches the array byte at that pointer. Read data appears on `bus_rdata` in the cycle after the access.
- R2: After reset, control A (index 10) reads 0x26, control B (index 11) reads 0x02, status C (index 12) reads 0x00 and status D (index 13) reads 0x80, and `irq` is low.
- R3: A host write to control A replaces bits 6:0. Bit 7, the update-in-progress flag, keeps its value.
- R4: A write to control B with bit 7 (freeze) set clears the update-in-progress flag at once. The update that was running is cancelled, and the time bytes are left as they were.
- R5: While control B bit 7 is set, a second strobe still pulses `cal_step`, but it starts no update window and leaves the time bytes unchanged.
- R6: A control B write that clears bit 7 while it was set pulses `cal_load` for that cycle. During that cycle `load_time` carries the array's time bytes (byte k of `load_time` is array index 2k for k<3, index k+3 otherwise).
- R7: A read of status C returns its value and clears it to 0x00. It also drops `irq` from the next cycle on.
- R8: Host writes to status C and status D have no effect.
- R9: A second strobe is acted on only when control A bits 6:4 equal 3'b010. Otherwise it pulses no `cal_step` and starts no update.
- R10: An accepted strobe with freeze clear sets update-in-progress for exactly UIP_CYCLES clock cycles. At the end of the window the time bytes (indices 0,2,4,6,7,8,9) take the values of `cal_time`, and the flag clears.
- R11: At the end of a window with control B bit 5 set, the alarm bytes at indices 1, 3 and 5 are compared against the second, minute and hour in their stored encoding. A byte whose bits 7:6 are 2'b11 matches any value. If all three match, status C gets 0xA0 ORed in and `irq` rises.
- R12: At the end of a window with control B bit 4 set, status C gets 0x90 ORed in and `irq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = pointer address, 1 = data address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| sec_pulse | input | 1 | One-second strobe from the oscillator divider |
| cal_time | input | 56 | Calendar time bytes, byte 0 seconds up to byte 6 year |
| cal_step | output | 1 | Request to the calendar to advance one second |
| cal_load | output | 1 | Request to the calendar to load `load_time` |
| load_time | output | 56 | Host-written time bytes for a calendar load |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch several rules on every cycle. The update flag drops after an end or a cancel. A window opens only with the divider field enabled. The flag survives control A writes. Status C keeps its value across host writes and clears on a read. An enabled end-of-update raises the interrupt with the right flag bits. The bench scenarios show the rest. These are the exact length of the window seen through register reads, the values copied into the time bytes, the don't-care alarm match against a real mismatch, the freeze and cancel paths that leave the time bytes untouched, and the contents of the load handed to the calendar.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int BYTE_W     = 8;
   localparam int TIME_BYTES = 7;
   localparam int N_ALARM    = 3;

   // control and status positions in the array
   localparam int IDX_CTL_A  = 10;
   localparam int IDX_CTL_B  = 11;
   localparam int IDX_STAT_C = 12;
   localparam int IDX_STAT_D = 13;

   localparam logic [7:0] CTL_A_RST  = 8'h26;
   localparam logic [7:0] CTL_B_RST  = 8'h02;
   localparam logic [7:0] STAT_D_VAL = 8'h80;

   localparam logic [7:0] FLAG_ALARM = 8'hA0;
   localparam logic [7:0] FLAG_UPEND = 8'h90;

   // array index of calendar byte k (sec, min, hour, wday, mday, month, year)
   function automatic int time_slot_idx(input int k);
      return (k < 3) ? 2 * k : k + 3;
   endfunction

   // array index of alarm byte a (sec, min, hour)
   function automatic int alarm_slot_idx(input int a);
      return 2 * a + 1;
   endfunction
endpackage

// File: rtl/rtc_hostif.sv
module rtc_hostif #(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_en,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [IDX_W-1:0] idx_data,
   output logic [IDX_W-1:0] idx_o,
   output logic             data_wr_o,
   output logic             data_rd_o
);
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= '0;
      else if (bus_en && bus_wr && !bus_addr) idx_q <= idx_data;
   end

   assign idx_o     = idx_q;
   assign data_wr_o = bus_en &  bus_wr & bus_addr;
   assign data_rd_o = bus_en & ~bus_wr & bus_addr;

   // R1
   idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && !bus_addr) |=> (idx_q == $past(idx_data)));
endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
   parameter int UIP_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_pulse,
   input  logic div_ok,
   input  logic set_mode,
   input  logic abort,
   output logic step_o,
   output logic busy_o,
   output logic end_o
);
   localparam int CW = $clog2(UIP_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(UIP_CYCLES - 1);

   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic          start, end_raw;

   assign step_o  = sec_pulse & div_ok;
   assign start   = step_o & ~set_mode & ~busy_q & ~abort;
   assign end_raw = busy_q & (cnt_q == '0);
   assign end_o   = end_raw & ~abort;
   assign busy_o  = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= CNT_LOAD;
      end else if (end_raw) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R4
   cancel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy_q);
   // R9
   start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(div_ok));
   // R10
   end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_o |=> !busy_q);
endmodule

// File: rtl/rtc_irq_ctl.sv
module rtc_irq_ctl
   import rtc_pkg::*;
#(
   parameter int N_ALM = N_ALARM
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    upd_end,
   input  logic                    alarm_en,
   input  logic                    upend_en,
   input  logic                    rd_clr,
   input  logic [BYTE_W*N_ALM-1:0] alm_bytes,
   input  logic [BYTE_W*N_ALM-1:0] now_bytes,
   output logic [BYTE_W-1:0]       flags_o,
   output logic                    irq_o
);
   logic [N_ALM-1:0]  hit;
   logic              alarm_fire;
   logic [BYTE_W-1:0] new_bits, flags_q;
   logic              irq_q;

   for (genvar g = 0; g < N_ALM; g++) begin : g_cmp
      assign hit[g] = (alm_bytes[BYTE_W*g+6 +: 2] == 2'b11) ||
                      (alm_bytes[BYTE_W*g +: BYTE_W] == now_bytes[BYTE_W*g +: BYTE_W]);
   end

   assign alarm_fire = upd_end & alarm_en & (&hit);
   assign new_bits   = (alarm_fire ? FLAG_ALARM : '0) |
                       ((upd_end & upend_en) ? FLAG_UPEND : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         flags_q <= (rd_clr ? '0 : flags_q) | new_bits;
         irq_q   <= (rd_clr ? 1'b0 : irq_q) | (|new_bits);
      end
   end

   assign flags_o = flags_q;
   assign irq_o   = irq_q;

   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !upd_end) |=> (flags_q == '0 && !irq_q));
   // R11
   alarm_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_end && alarm_en && (&hit)) |=> (irq_q && flags_q[7] && flags_q[5]));
   // R12
   upend_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_end && upend_en) |=> (irq_q && flags_q[7] && flags_q[4]));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
   import rtc_pkg::*;
#(
   parameter int ARR_DEPTH  = 128,
   parameter int UIP_CYCLES = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_en,
   input  logic                         bus_wr,
   input  logic                         bus_addr,
   input  logic [BYTE_W-1:0]            bus_wdata,
   output logic [BYTE_W-1:0]            bus_rdata,
   input  logic                         sec_pulse,
   input  logic [BYTE_W*TIME_BYTES-1:0] cal_time,
   output logic                         cal_step,
   output logic                         cal_load,
   output logic [BYTE_W*TIME_BYTES-1:0] load_time,
   output logic                         irq
);
   localparam int IDX_W = $clog2(ARR_DEPTH);

   if (ARR_DEPTH < 16 || (1 << IDX_W) != ARR_DEPTH) begin : g_bad_depth
      $error("ARR_DEPTH must be a power of two of at least 16");
   end
   if (IDX_W > BYTE_W) begin : g_bad_width
      $error("pointer must fit in one data byte");
   end
   if (UIP_CYCLES < 1) begin : g_bad_win
      $error("UIP_CYCLES must be at least 1");
   end

   logic [IDX_W-1:0]  idx;
   logic              wr_stb, rd_stb;
   logic              sel_a, sel_b, sel_c, sel_d, sel_ctl;
   logic              wr_a, wr_b, rd_c;
   logic              set_enter, set_leave;
   logic              busy, upd_end, div_ok;
   logic [6:0]        a_low;
   logic [BYTE_W-1:0] b_reg, c_flags, rd_mux;
   logic [BYTE_W-1:0] mem [ARR_DEPTH];
   logic [BYTE_W*N_ALARM-1:0] alm_bus;

   rtc_hostif #(.IDX_W(IDX_W)) u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .idx_data  (bus_wdata[IDX_W-1:0]),
      .idx_o     (idx),
      .data_wr_o (wr_stb),
      .data_rd_o (rd_stb)
   );

   assign sel_a   = (int'(idx) == IDX_CTL_A);
   assign sel_b   = (int'(idx) == IDX_CTL_B);
   assign sel_c   = (int'(idx) == IDX_STAT_C);
   assign sel_d   = (int'(idx) == IDX_STAT_D);
   assign sel_ctl = sel_a | sel_b | sel_c | sel_d;

   assign wr_a      = wr_stb & sel_a;
   assign wr_b      = wr_stb & sel_b;
   assign rd_c      = rd_stb & sel_c;
   assign set_enter = wr_b & bus_wdata[7];
   assign set_leave = wr_b & ~bus_wdata[7] & b_reg[7];
   assign div_ok    = (a_low[6:4] == 3'b010);

   rtc_upd_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_pulse (sec_pulse),
      .div_ok    (div_ok),
      .set_mode  (b_reg[7]),
      .abort     (set_enter),
      .step_o    (cal_step),
      .busy_o    (busy),
      .end_o     (upd_end)
   );

   // control registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_low <= CTL_A_RST[6:0];
         b_reg <= CTL_B_RST;
      end else begin
         if (wr_a) a_low <= bus_wdata[6:0];
         if (wr_b) b_reg <= bus_wdata;
      end
   end

   // byte array: host writes first, end-of-update refresh overrides
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ARR_DEPTH; i++) mem[i] <= '0;
      end else begin
         if (wr_stb && !sel_ctl) mem[idx] <= bus_wdata;
         if (upd_end) begin
            for (int k = 0; k < TIME_BYTES; k++)
               mem[time_slot_idx(k)] <= cal_time[BYTE_W*k +: BYTE_W];
         end
      end
   end

   for (genvar k = 0; k < TIME_BYTES; k++) begin : g_load
      assign load_time[BYTE_W*k +: BYTE_W] = mem[time_slot_idx(k)];
   end
   assign cal_load = set_leave;

   for (genvar a = 0; a < N_ALARM; a++) begin : g_alm
      assign alm_bus[BYTE_W*a +: BYTE_W] = mem[alarm_slot_idx(a)];
   end

   rtc_irq_ctl #(.N_ALM(N_ALARM)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_end   (upd_end),
      .alarm_en  (b_reg[5]),
      .upend_en  (b_reg[4]),
      .rd_clr    (rd_c),
      .alm_bytes (alm_bus),
      .now_bytes (cal_time[BYTE_W*N_ALARM-1:0]),
      .flags_o   (c_flags),
      .irq_o     (irq)
   );

   always_comb begin
      if (sel_a)      rd_mux = {busy, a_low};
      else if (sel_b) rd_mux = b_reg;
      else if (sel_c) rd_mux = c_flags;
      else if (sel_d) rd_mux = STAT_D_VAL;
      else            rd_mux = mem[idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                           bus_rdata <= '0;
      else if (rd_stb)                      bus_rdata <= rd_mux;
      else if (bus_en && !bus_wr && !bus_addr) bus_rdata <= 8'hFF;
   end

   // R3
   uip_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && busy && !upd_end && !set_enter) |=> busy);
   // R8
   stat_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && sel_c && !upd_end) |=> (c_flags == $past(c_flags)));
   // R6
   load_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_load |-> (b_reg[7] && !busy));
endmodule

// File: tb/rtc_regport_bench.sv
`timescale 1ns/1ps
module rtc_regport_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        sec_pulse = 1'b0;
   logic [55:0] cal_time = '0;
   logic        cal_step, cal_load, irq;
   logic [55:0] load_time;

   int checks = 0;
   int errors = 0;
   logic        load_s, step_s;
   logic [55:0] ltime_s;
   logic [7:0]  rv;
   int          cur_idx = 0;

   always #2.5 clk = ~clk;

   rtc_regport u_rtc_regport (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sec_pulse(sec_pulse), .cal_time(cal_time), .cal_step(cal_step),
      .cal_load(cal_load), .load_time(load_time), .irq(irq)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus(input logic wr, input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
      #1 load_s = cal_load; ltime_s = load_time;
      @(posedge clk);
      #1 bus_en = 1'b0;
      rv = bus_rdata;
      if (wr && !a) cur_idx = int'(d[6:0]);
   endtask

   task automatic set_idx(input int i);  bus(1'b1, 1'b0, 8'(i)); endtask
   task automatic wr_dat(input logic [7:0] d); bus(1'b1, 1'b1, d); endtask
   task automatic rd_dat(); bus(1'b0, 1'b1, 8'h00); endtask
   task automatic wr_at(input int i, input logic [7:0] d); set_idx(i); wr_dat(d); endtask
   task automatic rd_at(input int i); set_idx(i); rd_dat(); endtask

   task automatic tick();
      @(negedge clk);
      sec_pulse = 1'b1;
      #1 step_s = cal_step;
      @(posedge clk);
      #1 sec_pulse = 1'b0;
   endtask

   task automatic idle(input int n); repeat (n) @(posedge clk); #1; endtask

   // {op[1:0], data[7:0], expected[7:0]}; op 0 = pointer, 1 = write, 2 = read and compare
   localparam int NV = 23;
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 8'h20, 8'h00}, {2'd1, 8'h5A, 8'h00}, {2'd0, 8'h21, 8'h00},
      {2'd1, 8'hC3, 8'h00}, {2'd0, 8'h20, 8'h00}, {2'd2, 8'h00, 8'h5A},
      {2'd0, 8'h21, 8'h00}, {2'd2, 8'h00, 8'hC3}, {2'd0, 8'hFF, 8'h00},
      {2'd1, 8'h33, 8'h00}, {2'd0, 8'h7F, 8'h00}, {2'd2, 8'h00, 8'h33},
      {2'd0, 8'h0C, 8'h00}, {2'd1, 8'hFF, 8'h00}, {2'd2, 8'h00, 8'h00},
      {2'd0, 8'h0D, 8'h00}, {2'd1, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h80},
      {2'd0, 8'h0A, 8'h00}, {2'd1, 8'hA5, 8'h00}, {2'd2, 8'h00, 8'h25},
      {2'd1, 8'h26, 8'h00}, {2'd2, 8'h00, 8'h26}
   };

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R2 reset state
      check("R2 irq", irq, 0);
      rd_at(10); check("R2 ctl A", rv, 8'h26);
      rd_at(11); check("R2 ctl B", rv, 8'h02);
      rd_at(12); check("R2 stat C", rv, 8'h00);
      rd_at(13); check("R2 stat D", rv, 8'h80);

      // R1 R3 R8 table walk
      for (int v = 0; v < NV; v++) begin
         logic [1:0] op;
         op = VEC[v][17:16];
         if (op == 2'd0) set_idx(int'(VEC[v][15:8]));
         else if (op == 2'd1) wr_dat(VEC[v][15:8]);
         else begin
            rd_dat();
            if (cur_idx == 12 || cur_idx == 13) check("R8 table", rv, VEC[v][7:0]);
            else if (cur_idx == 10)              check("R3 table", rv, VEC[v][7:0]);
            else                                 check("R1 table", rv, VEC[v][7:0]);
         end
      end
      bus(1'b0, 1'b0, 8'h00); check("R1 even read", rv, 8'hFF);

      // R10 exact window and refresh
      cal_time = 56'h24_06_15_03_12_34_10;
      set_idx(10);
      tick(); check("R9 step when enabled", step_s, 1);
      rd_dat(); check("R10 uip first", rv, 8'hA6);
      idle(6);
      rd_dat(); check("R10 uip last", rv, 8'hA6);
      rd_dat(); check("R10 uip cleared", rv, 8'h26);
      rd_at(0); check("R10 sec refreshed", rv, 8'h10);
      rd_at(4); check("R10 hour refreshed", rv, 8'h12);
      rd_at(9); check("R10 year refreshed", rv, 8'h24);

      // R3 write during window keeps UIP
      set_idx(10);
      tick();
      wr_dat(8'h06);
      rd_dat(); check("R3 uip kept", rv, 8'h86);
      idle(8);
      rd_dat(); check("R3 low bits", rv, 8'h06);
      wr_dat(8'h26);

      // R11 alarm with don't-care minute
      cal_time = 56'h24_06_15_03_13_59_30;
      wr_at(1, 8'h30); wr_at(3, 8'hC5); wr_at(5, 8'h13);
      wr_at(11, 8'h22);
      tick(); idle(10);
      check("R11 irq up", irq, 1);
      rd_at(12); check("R11 flags", rv, 8'hA0);
      check("R7 irq dropped", irq, 0);
      rd_dat(); check("R7 cleared", rv, 8'h00);
      wr_at(5, 8'h14);
      tick(); idle(10);
      check("R11 mismatch irq", irq, 0);
      rd_at(12); check("R11 mismatch flags", rv, 8'h00);

      // R12 update-ended
      wr_at(11, 8'h12);
      tick(); idle(10);
      check("R12 irq up", irq, 1);
      rd_at(12); check("R12 flags", rv, 8'h90);
      check("R7 irq low", irq, 0);

      // R9 divider stopped
      cal_time = 56'h24_06_15_03_13_59_40;
      wr_at(10, 8'h76);
      tick(); check("R9 no step", step_s, 0);
      idle(10);
      check("R9 no irq", irq, 0);
      rd_dat(); check("R9 no uip", rv, 8'h76);
      rd_at(0); check("R9 time held", rv, 8'h30);
      wr_at(10, 8'h26);
      wr_at(11, 8'h02);

      // R4 freeze cancels running window
      cal_time = 56'h24_06_15_03_13_59_41;
      set_idx(11);
      tick();
      wr_dat(8'h82);
      rd_at(10); check("R4 uip cleared", rv, 8'h26);
      idle(10);
      rd_at(0); check("R4 time kept", rv, 8'h30);

      // R5 frozen
      cal_time = 56'h24_06_15_03_13_59_42;
      set_idx(10);
      tick(); check("R5 step continues", step_s, 1);
      rd_dat(); check("R5 no uip", rv, 8'h26);
      idle(10);
      rd_at(0); check("R5 time frozen", rv, 8'h30);

      // R6 leaving freeze hands time to calendar
      wr_at(0, 8'h45); wr_at(4, 8'h21);
      set_idx(11);
      wr_dat(8'h02);
      check("R6 load pulse", load_s, 1);
      check("R6 load sec", ltime_s[7:0], 8'h45);
      check("R6 load hour", ltime_s[23:16], 8'h21);
      wr_dat(8'h02);
      check("R6 no second load", load_s, 0);
      rd_at(0); check("R6 sec kept", rv, 8'h45);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule